// File: doc/BRIEF.md
# Phase-Offset PWM Generator

This block drives up to four pulse-width-modulated outputs from one clock. Each channel runs its own up-counter over a programmable period and holds its output high for a programmable number of cycles at the start of each period. A common phase counter begins at zero whenever the channels are restarted. A channel does not begin counting until the phase counter equals that channel's offset, so the offsets set fixed phase delays between the outputs.

Configuration writes land in per-channel shadow registers. A single load strobe copies every shadow value into the working set at once and restarts all channels together. When the sync mode input is high at a load, or during reset, the phase counter stays parked until a falling edge on the external sync line. That line is first passed through a two-flop synchroniser. To re-align the outputs to a later sync event, software raises the sync line and issues another load.

Top module: `pwm_phase_gen`

## Requirements
- R1: While reset is high, every output is low. Reset puts period 10, width 7 and offset 0 into every channel's shadow and working settings. The last reset edge acts as a load edge, with the sync mode sampled on that edge.
- R2: Once a channel has started, its output is high for the first `width` cycles of each period and low for the remaining `period - width` cycles. The pattern then repeats every `period` cycles.
- R3: A channel whose working period is 0 keeps its output low at all times.
- R4: Take L as the clock edge that commits a load, with no sync wait. A channel with offset k first drives high in the cycle that follows edge L+1+k, so channels with offset 0 all start on the same cycle.
- R5: A write sets one field of the channel picked by `cfg_chan`. The field is chosen by `cfg_field`: 0 = period, 1 = width, 2 = offset, and code 3 is ignored. A write has no effect on any output until `cfg_load` is asserted. The load then commits the shadow values of all channels together.
- R6: While the block waits for the phase start or for a sync edge, all outputs are low.
- R7: If `sync_mode_en` is high at a load edge, the block waits for a sync edge. Let E be the first clock edge that samples `ext_sync` low after it was high. Edge E+2 then plays the role of the load edge L in R4. Rising edges and steady levels on `ext_sync` do not release the wait. Sync edges that arrive after release have no effect.
- R8: If a channel's width is greater than or equal to a nonzero period, its output stays high for the whole period once the channel has started.
- R9: A later load in sync mode stops all channels again, even when they are running. The channels stay stopped until the next sync falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one shadow field |
| cfg_chan | input | 2 | Channel selected by the write |
| cfg_field | input | 2 | Field code: 0 period, 1 width, 2 offset |
| cfg_data | input | 8 | Value written into the selected field |
| cfg_load | input | 1 | Commits all shadow values and restarts the channels |
| sync_mode_en | input | 1 | When high at a load, start waits for a sync falling edge |
| ext_sync | input | 1 | Asynchronous external sync line |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The assertions rely on two assumptions about the inputs. First, `cfg_load` and reset are the only events that change a channel's working settings. Second, the sync mode seen at a load edge is a clean level. The stimulus meets both by changing every input on the falling clock edge, and by holding `ext_sync` at one level for at least three clock cycles before each transition. This settles the synchroniser pipeline, so each falling edge gives exactly one detection. Offsets stay small next to the 8-bit phase counter, so the counter never saturates before a channel starts.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

    localparam int CFG_W     = 8;
    localparam int FIELD_W   = 2;
    localparam int RST_PER   = 10;
    localparam int RST_WID   = 7;
    localparam int RST_OFS   = 0;

    typedef enum logic [FIELD_W-1:0] {
        FLD_PERIOD = 2'd0,
        FLD_WIDTH  = 2'd1,
        FLD_OFFSET = 2'd2,
        FLD_NONE   = 2'd3
    } cfg_field_e;

    typedef enum logic {
        PH_WAIT = 1'b0,
        PH_RUN  = 1'b1
    } phase_state_e;

    typedef struct packed {
        logic [CFG_W-1:0] period;
        logic [CFG_W-1:0] width;
        logic [CFG_W-1:0] offset;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{
        period: CFG_W'(RST_PER),
        width:  CFG_W'(RST_WID),
        offset: CFG_W'(RST_OFS)
    };

    // Output level for a started channel at a given count.
    function automatic logic pwm_level(input logic [CFG_W-1:0] cnt,
                                       input chan_cfg_t cfg);
        return (cfg.period != '0) && (cnt < cfg.width);
    endfunction

endpackage

// File: rtl/pwm_sync_fall.sv
module pwm_sync_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall_o = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/pwm_phase_ctrl.sv
module pwm_phase_ctrl
    import pwm_phase_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             mode_i,
    input  logic             fall_i,
    output logic             run_o,
    output logic [CFG_W-1:0] ofs_o
);
    phase_state_e     state_q;
    logic [CFG_W-1:0] ofs_q;

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            state_q <= mode_i ? PH_WAIT : PH_RUN;
            ofs_q   <= '0;
        end else if (state_q == PH_WAIT) begin
            if (fall_i) begin
                state_q <= PH_RUN;
                ofs_q   <= '0;
            end
        end else if (ofs_q != '1) begin
            ofs_q <= ofs_q + CFG_W'(1);
        end
    end

    assign run_o = (state_q == PH_RUN);
    assign ofs_o = ofs_q;

    AST_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_i) && $past(state_q == PH_WAIT) && state_q == PH_RUN)
        |-> $past(fall_i)); // R7

    AST_OFS_MONO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_i) && $past(run_o) && run_o)
        |-> ofs_q >= $past(ofs_q)); // R4

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_phase_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  cfg_field_e       wr_field,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [CFG_W-1:0] ofs_i,
    output logic             pwm_o
);
    chan_cfg_t        shadow_q;
    chan_cfg_t        active_q;
    logic             started_q;
    logic [CFG_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = ({1'b0, cnt_q} + (CFG_W+1)'(1)) >= {1'b0, active_q.period};

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q  <= CFG_RESET;
            active_q  <= CFG_RESET;
            started_q <= 1'b0;
            cnt_q     <= '0;
        end else begin
            if (wr_en) begin
                case (wr_field)
                    FLD_PERIOD: shadow_q.period <= wr_data;
                    FLD_WIDTH:  shadow_q.width  <= wr_data;
                    FLD_OFFSET: shadow_q.offset <= wr_data;
                    default:    ;
                endcase
            end
            if (load_i) begin
                active_q  <= shadow_q;
                started_q <= 1'b0;
                cnt_q     <= '0;
            end else if (run_i) begin
                if (!started_q) begin
                    if (ofs_i == active_q.offset) started_q <= 1'b1;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= wrap ? '0 : cnt_q + CFG_W'(1);
                end
            end
        end
    end

    assign pwm_o = started_q && pwm_level(cnt_q, active_q);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (active_q.period != '0) |-> (cnt_q < active_q.period)); // R2

    AST_START_AT_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(started_q))
        |-> ($past(run_i) && $past(ofs_i) == active_q.offset)); // R4

endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
    import pwm_phase_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 cfg_we,
    input  logic [((N_CH > 1) ? $clog2(N_CH) : 1)-1:0] cfg_chan,
    input  logic [FIELD_W-1:0]                   cfg_field,
    input  logic [CFG_W-1:0]                     cfg_data,
    input  logic                                 cfg_load,
    input  logic                                 sync_mode_en,
    input  logic                                 ext_sync,
    output logic [N_CH-1:0]                      pwm_out
);
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic             sync_fall;
    logic             run;
    logic [CFG_W-1:0] ofs;

    pwm_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ext_sync),
        .fall_o  (sync_fall)
    );

    pwm_phase_ctrl u_phase (
        .clk    (clk),
        .rst    (rst),
        .load_i (cfg_load),
        .mode_i (sync_mode_en),
        .fall_i (sync_fall),
        .run_o  (run),
        .ofs_o  (ofs)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        pwm_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (cfg_we && (cfg_chan == CH_W'(i))),
            .wr_field (cfg_field_e'(cfg_field)),
            .wr_data  (cfg_data),
            .load_i   (cfg_load),
            .run_i    (run),
            .ofs_i    (ofs),
            .pwm_o    (pwm_out[i])
        );
    end

    AST_WAIT_LOW: assert property (@(posedge clk) disable iff (rst)
        !run |-> (pwm_out == '0)); // R6

endmodule

// File: tb/pwm_phase_gen_tb.sv
module pwm_phase_gen_tb;
    localparam int NC = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_chan = '0;
    logic [1:0] cfg_field = '0;
    logic [7:0] cfg_data = '0;
    logic       cfg_load = 1'b0;
    logic       sync_mode_en = 1'b0;
    logic       ext_sync = 1'b0;
    logic [NC-1:0] pwm_out;

    always #10 clk = ~clk;

    pwm_phase_gen #(.N_CH(NC), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_field(cfg_field), .cfg_data(cfg_data), .cfg_load(cfg_load),
        .sync_mode_en(sync_mode_en), .ext_sync(ext_sync), .pwm_out(pwm_out)
    );

    int ecount = 0;
    always @(posedge clk) ecount <= ecount + 1;

    int checks = 0;
    int fails  = 0;
    int s_per[NC], s_wid[NC], s_off[NC];
    int a_per[NC], a_wid[NC], a_off[NC];
    bit m_run = 1'b0;
    int m_l   = 0;

    function automatic bit exp_lvl(int ch, int e);
        int n, m;
        if (!m_run) return 1'b0;
        n = e - m_l;
        m = n - (a_off[ch] + 1);
        if (m < 0 || a_per[ch] == 0) return 1'b0;
        return (m % a_per[ch]) < a_wid[ch];
    endfunction

    task automatic chk(bit act, bit exp, string tag, int ch);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s ch%0d edge %0d: got %0b expected %0b", tag, ch, ecount, act, exp);
        end
    endtask

    task automatic check_span(int cyc, string tag);
        for (int c = 0; c < cyc; c++) begin
            @(posedge clk); #5;
            for (int ch = 0; ch < NC; ch++) chk(pwm_out[ch], exp_lvl(ch, ecount), tag, ch);
        end
    endtask

    task automatic wr(int ch, int fld, int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_field = 2'(fld); cfg_data = 8'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (fld == 0) s_per[ch] = val;
        else if (fld == 1) s_wid[ch] = val;
        else if (fld == 2) s_off[ch] = val;
    endtask

    task automatic do_load();
        @(negedge clk);
        cfg_load = 1'b1;
        @(posedge clk); #1;
        m_l = ecount;
        m_run = !sync_mode_en;
        for (int ch = 0; ch < NC; ch++) begin
            a_per[ch] = s_per[ch]; a_wid[ch] = s_wid[ch]; a_off[ch] = s_off[ch];
        end
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic release_sync();
        @(negedge clk);
        ext_sync = 1'b0;
        @(posedge clk); #1;
        m_l = ecount + 2;
        m_run = 1'b1;
    endtask

    task automatic set_sync(bit v);
        @(negedge clk);
        ext_sync = v;
    endtask

    bit done = 1'b0;

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int ch = 0; ch < NC; ch++) begin
            s_per[ch] = 10; s_wid[ch] = 7; s_off[ch] = 0;
            a_per[ch] = 10; a_wid[ch] = 7; a_off[ch] = 0;
        end
        // R1: outputs low during reset; last reset edge acts as a load
        repeat (3) @(posedge clk);
        #1;
        for (int ch = 0; ch < NC; ch++) chk(pwm_out[ch], 1'b0, "R1", ch);
        m_l = ecount;
        m_run = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_span(35, "R1 R2");

        // R5: shadow writes invisible before the load
        wr(0, 0, 5); wr(0, 1, 2); wr(0, 2, 0);
        wr(1, 0, 8); wr(1, 1, 3); wr(1, 2, 3);
        wr(2, 0, 0); wr(2, 1, 4); wr(2, 2, 1);
        wr(3, 0, 6); wr(3, 1, 9); wr(3, 2, 5);
        wr(0, 3, 1);  // field code 3 ignored
        check_span(12, "R5");
        do_load();
        check_span(60, "R2 R3 R4 R5 R8");

        // Sweep of period and width, staggered offsets
        for (int p = 1; p <= 6; p++) begin
            for (int w = 0; w <= 7; w++) begin
                for (int ch = 0; ch < NC; ch++) begin
                    wr(ch, 0, p); wr(ch, 1, w); wr(ch, 2, ch * (p % 3 + 1));
                end
                do_load();
                check_span(2 * p + 12, "R2 R4 R8");
            end
        end

        // R6 R7: sync mode wait and release
        for (int ch = 0; ch < NC; ch++) begin
            wr(ch, 0, 4 + ch); wr(ch, 1, 2); wr(ch, 2, 2 * ch);
        end
        @(negedge clk);
        sync_mode_en = 1'b1;
        ext_sync = 1'b1;
        check_span(5, "R2");
        do_load();
        check_span(8, "R6");
        release_sync();
        check_span(30, "R7");
        // R7: sync edges while running are ignored
        set_sync(1'b1);
        check_span(5, "R7");
        set_sync(1'b0);
        check_span(12, "R7");

        // R9: re-arm with sync held high, then a fresh falling edge
        set_sync(1'b1);
        check_span(4, "R9");
        do_load();
        check_span(8, "R9");
        release_sync();
        check_span(25, "R9");

        // R7: load with sync low; a rising edge must not release
        do_load();
        check_span(5, "R6");
        set_sync(1'b1);
        check_span(8, "R7");
        release_sync();
        check_span(25, "R7");

        // Back to free-running mode: load starts at once
        @(negedge clk);
        sync_mode_en = 1'b0;
        do_load();
        check_span(20, "R4");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule